// File: doc/BRIEF.md
# Same-Width Permuted Congruential Random Generator

This block produces a stream of 32-bit pseudorandom words from a 32-bit congruential state. The output is as wide as the state, which suits places where only a few flops can be spent on a generator. Each accepted step request does two things. It advances the state by one multiply-add modulo 2^32. It also passes the state value held before that advance through a three-stage output permutation. The first stage is an xorshift whose distance depends on the data. The second is a multiply by a fixed odd constant. The third is a fixed xorshift.

A seed is written through a load strobe. The state becomes the seed plus the increment, and the block then spends exactly one cycle advancing once on its own. That first value is never delivered. A small two-state controller handles this. In state PH_WARM the block performs the warm-up advance and moves to PH_RUN without producing output. In PH_RUN a step request is accepted, the state advances, and the permuted result is scheduled. From either state, a load moves the block to PH_WARM; this load transition has priority over everything else. Reset behaves like a load of the `RESET_SEED` parameter. The multiply can sit behind an optional pipeline register (`PIPE`). The valid flag is delayed to match, so that every accepted request yields exactly one output, in order.

Top module: `pcg_rxs_gen`

## Requirements
- R1: While `rst_n` is low, `rnd_valid` is 0. After release the state is `RESET_SEED + INCREMENT`. The first clock edge after release is a warm-up advance, and the first accepted request then delivers the permutation of `(RESET_SEED + INCREMENT) * 747796405 + INCREMENT` (mod 2^32).
- R2: Each accepted request replaces the state S with `S * 747796405 + INCREMENT` mod 2^32. With no request, no load and the controller in PH_RUN, the state does not change.
- R3: The delivered word is the permutation of the state held before the update in the same edge. The count c is state bits 31..28, and the first stage is `x = S ^ (S >> (4 + c))`, so shift distances range from 4 to 19.
- R4: The second stage keeps the low 32 bits of `x * 277803737`, giving y. The delivered word is `y ^ (y >> 22)`.
- R5: A load sets the state to `load_seed + INCREMENT` and enters PH_WARM. The following edge advances the state once and enters PH_RUN with no output, so the first accepted request after a load delivers the permutation of `(load_seed + INCREMENT) * 747796405 + INCREMENT`.
- R6: A request in the same cycle as a load, or in a PH_WARM cycle, is ignored. It produces no output and does not advance the state.
- R7: `rnd_valid` is 1 for exactly one cycle per accepted request, `1 + PIPE` edges after the accepting edge; at all other times it is 0.
- R8: Requests on consecutive cycles are all accepted and produce consecutive outputs, in request order.
- R9: An output already in flight in the pipeline is still delivered, with its value unchanged, when a load arrives in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Seed load strobe (highest priority) |
| load_seed | input | 32 | Seed value taken when `load_en` is 1 |
| step_req | input | 1 | Request for one output word |
| rnd_data | output | 32 | Registered permuted output word |
| rnd_valid | output | 1 | `rnd_data` holds a new word this cycle |

## Verification
The two functions that can meet in one cycle are a seed load and a step request. There are two cases: the request arrives in the same cycle as the load, or it arrives while an earlier accepted request is still in the multiply pipeline. The bench drives load and request together, and also drives a request during the warm-up cycle. It then expects no output from those requests, and expects the next accepted word to come from the freshly seeded state. It also loads in the cycle right after a request and expects the in-flight word to arrive on time with its pre-load value. Every cycle the bench compares the valid flag and the data against a schedule of expected words. It builds that schedule with its own arithmetic model of the update and the permutation.

// File: rtl/pcg_rxs_pkg.sv
package pcg_rxs_pkg;

    localparam int unsigned STATE_W    = 32;
    localparam int unsigned CNT_W      = 4;
    localparam int unsigned BASE_SHIFT = 4;
    localparam int unsigned TAIL_SHIFT = 22;

    localparam logic [STATE_W-1:0] LCG_MUL  = 32'd747796405;
    localparam logic [STATE_W-1:0] PERM_MUL = 32'd277803737;

    typedef enum logic [0:0] {
        PH_WARM = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    function automatic logic [STATE_W-1:0] lcg_advance(
        input logic [STATE_W-1:0] s,
        input logic [STATE_W-1:0] inc
    );
        return s * LCG_MUL + inc;
    endfunction

endpackage

// File: rtl/pcg_rxs_core.sv
module pcg_rxs_core
    import pcg_rxs_pkg::*;
#(
    parameter logic [STATE_W-1:0] RESET_SEED = 32'h1234_5678,
    parameter logic [STATE_W-1:0] INCREMENT  = 32'd2891336453
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [STATE_W-1:0] load_seed,
    input  logic               step_req,
    output logic               take_o,
    output logic [STATE_W-1:0] cur_o,
    output phase_t             phase_o
);

    phase_t             phase_q, phase_d;
    logic [STATE_W-1:0] state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_WARM;
            state_q <= RESET_SEED + INCREMENT;
        end else begin
            phase_q <= phase_d;
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        phase_d = phase_q;
        state_d = state_q;
        if (load_en) begin
            phase_d = PH_WARM;
            state_d = load_seed + INCREMENT;
        end else begin
            unique case (phase_q)
                PH_WARM: begin
                    phase_d = PH_RUN;
                    state_d = lcg_advance(state_q, INCREMENT);
                end
                PH_RUN: begin
                    if (step_req) begin
                        state_d = lcg_advance(state_q, INCREMENT);
                    end
                end
                default: begin
                    phase_d = PH_WARM;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        take_o  = step_req && !load_en && (phase_q == PH_RUN);
        cur_o   = state_q;
        phase_o = phase_q;
    end

endmodule

// File: rtl/pcg_rxs_xshift.sv
module pcg_rxs_xshift
    import pcg_rxs_pkg::*;
(
    input  logic [STATE_W-1:0] x_i,
    output logic [STATE_W-1:0] y_o
);

    logic [CNT_W-1:0]   cnt;
    logic [STATE_W-1:0] stg [0:CNT_W];

    assign cnt    = x_i[STATE_W-1 -: CNT_W];
    assign stg[0] = x_i >> BASE_SHIFT;

    for (genvar i = 0; i < CNT_W; i++) begin : g_lvl
        assign stg[i+1] = cnt[i] ? (stg[i] >> (1 << i)) : stg[i];
    end

    assign y_o = x_i ^ stg[CNT_W];

endmodule

// File: rtl/pcg_rxs_mulxs.sv
module pcg_rxs_mulxs
    import pcg_rxs_pkg::*;
(
    input  logic [STATE_W-1:0] x_i,
    output logic [STATE_W-1:0] z_o
);

    logic [STATE_W-1:0] prod;

    assign prod = x_i * PERM_MUL;
    assign z_o  = prod ^ (prod >> TAIL_SHIFT);

endmodule

// File: rtl/pcg_rxs_gen.sv
module pcg_rxs_gen
    import pcg_rxs_pkg::*;
#(
    parameter bit                 PIPE       = 1'b1,
    parameter logic [STATE_W-1:0] RESET_SEED = 32'h1234_5678,
    parameter logic [STATE_W-1:0] INCREMENT  = 32'd2891336453
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [STATE_W-1:0] load_seed,
    input  logic               step_req,
    output logic [STATE_W-1:0] rnd_data,
    output logic               rnd_valid
);

    logic               take;
    logic [STATE_W-1:0] state_q;
    phase_t             phase_q;
    logic [STATE_W-1:0] xs_val;
    logic [STATE_W-1:0] mid_val;
    logic               mid_vld;
    logic [STATE_W-1:0] perm_val;

    pcg_rxs_core #(
        .RESET_SEED (RESET_SEED),
        .INCREMENT  (INCREMENT)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_seed (load_seed),
        .step_req  (step_req),
        .take_o    (take),
        .cur_o     (state_q),
        .phase_o   (phase_q)
    );

    pcg_rxs_xshift u_xs (
        .x_i (state_q),
        .y_o (xs_val)
    );

    if (PIPE) begin : g_pipe
        logic [STATE_W-1:0] s1_q;
        logic               s1_v;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= '0;
                s1_v <= 1'b0;
            end else begin
                s1_v <= take;
                if (take) s1_q <= xs_val;
            end
        end
        assign mid_val = s1_q;
        assign mid_vld = s1_v;
    end else begin : g_comb
        assign mid_val = xs_val;
        assign mid_vld = take;
    end

    pcg_rxs_mulxs u_mx (
        .x_i (mid_val),
        .z_o (perm_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_data  <= '0;
            rnd_valid <= 1'b0;
        end else begin
            rnd_valid <= mid_vld;
            if (mid_vld) rnd_data <= perm_val;
        end
    end

endmodule

// File: rtl/pcg_rxs_chk.sv
module pcg_rxs_chk
    import pcg_rxs_pkg::*;
#(
    parameter bit                 PIPE      = 1'b1,
    parameter logic [STATE_W-1:0] INCREMENT = 32'd2891336453
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_en,
    input logic [STATE_W-1:0] load_seed,
    input logic               step_req,
    input logic               rnd_valid,
    input logic [STATE_W-1:0] state_q,
    input phase_t             phase_q
);

    localparam int unsigned LAT = PIPE ? 2 : 1;

    function automatic logic [STATE_W-1:0] seeded_warm(input logic [STATE_W-1:0] sd);
        logic [STATE_W-1:0] t;
        t = sd + INCREMENT;
        return lcg_advance(t, INCREMENT);
    endfunction

    // R7
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> $past(step_req, LAT));

    // R6
    load_swallows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> (!$past(load_en, LAT) && ($past(phase_q, LAT) == PH_RUN)));

    // R5
    warm_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_en, 2) && !$past(load_en)) |-> (state_q == seeded_warm($past(load_seed, 2))));

    // R5
    load_enters_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (phase_q == PH_WARM));

    // R2
    idle_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN && !load_en && !step_req) |=> $stable(state_q));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !rnd_valid);

endmodule

bind pcg_rxs_gen pcg_rxs_chk #(
    .PIPE      (PIPE),
    .INCREMENT (INCREMENT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_seed (load_seed),
    .step_req  (step_req),
    .rnd_valid (rnd_valid),
    .state_q   (state_q),
    .phase_q   (phase_q)
);

// File: tb/test_pcg_rxs_gen.sv
module test_pcg_rxs_gen;

    localparam bit          PIPE  = 1'b1;
    localparam logic [31:0] RSEED = 32'h1234_5678;
    localparam logic [31:0] INC   = 32'd2891336453;
    localparam int          SLOTS = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_seed = '0;
    logic        step_req = 1'b0;
    logic [31:0] rnd_data;
    logic        rnd_valid;

    pcg_rxs_gen #(.PIPE(PIPE), .RESET_SEED(RSEED), .INCREMENT(INC)) i_pcg_rxs_gen (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_seed(load_seed),
        .step_req(step_req), .rnd_data(rnd_data), .rnd_valid(rnd_valid)
    );

    always #5 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    string       tag = "R1";
    logic [31:0] m_state;
    bit          m_warm;
    int          edge_n = 0;
    logic        exp_v [SLOTS];
    logic [31:0] exp_d [SLOTS];
    bit          seen_cnt [16];

    function automatic logic [31:0] adv(input logic [31:0] s);
        return s * 32'd747796405 + INC;
    endfunction

    function automatic logic [31:0] perm(input logic [31:0] s);
        logic [31:0] x;
        int c;
        c = int'(s >> 28);
        x = s ^ (s >> (4 + c));
        x = x * 32'd277803737;
        return x ^ (x >> 22);
    endfunction

    task automatic fail_line(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_bad++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic step(input logic ld, input logic [31:0] sd, input logic nx);
        int slot;
        load_en   = ld;
        load_seed = sd;
        step_req  = nx;
        @(posedge clk);
        edge_n++;
        if (ld) begin
            m_state = sd + INC;
            m_warm  = 1;
        end else if (m_warm) begin
            m_state = adv(m_state);
            m_warm  = 0;
        end else if (nx) begin
            slot = (edge_n + int'(PIPE)) % SLOTS;
            exp_v[slot] = 1'b1;
            exp_d[slot] = perm(m_state);
            seen_cnt[m_state[31:28]] = 1;
            m_state = adv(m_state);
        end
        @(negedge clk);
        slot = edge_n % SLOTS;
        n_chk++;
        if (rnd_valid !== exp_v[slot])
            fail_line("valid", {31'd0, rnd_valid}, {31'd0, exp_v[slot]});
        else if (exp_v[slot] && rnd_data !== exp_d[slot])
            fail_line("data", rnd_data, exp_d[slot]);
        exp_v[slot] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
        for (int i = 0; i < 16; i++) seen_cnt[i] = 0;

        // R1: quiet during reset
        tag = "R1";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            n_chk++;
            if (rnd_valid !== 1'b0) fail_line("valid in reset", {31'd0, rnd_valid}, 32'd0);
        end
        rst_n   = 1'b1;
        m_state = RSEED + INC;
        m_warm  = 1;
        step(1'b0, 32'd0, 1'b1);   // warm-up edge: request ignored (R6)
        step(1'b0, 32'd0, 1'b1);   // first accepted after reset (R1)
        idle(3);

        // R7: spaced requests, exact latency
        tag = "R7";
        for (int g = 1; g <= 4; g++) begin
            step(1'b0, 32'd0, 1'b1);
            idle(g);
        end

        // R8: back-to-back requests
        tag = "R8";
        for (int i = 0; i < 40; i++) step(1'b0, 32'd0, 1'b1);
        idle(3);

        // R2: mixed request pattern over a long run
        tag = "R2";
        for (int i = 0; i < 300; i++) step(1'b0, 32'd0, (i % 3) != 0);
        idle(3);

        // R3: sweep of seeds with every top nibble, run each for a while
        tag = "R3";
        for (int k = 0; k < 16; k++) begin
            step(1'b1, {k[3:0], 28'h9E3_779B}, 1'b0);
            idle(1);
            for (int i = 0; i < 40; i++) step(1'b0, 32'd0, 1'b1);
        end
        idle(3);
        for (int k = 0; k < 16; k++) begin
            n_chk++;
            if (!seen_cnt[k]) fail_line("count never used", 32'(k), 32'(k));
        end

        // R4: extreme seeds
        tag = "R4";
        step(1'b1, 32'h0000_0000, 1'b0); idle(1);
        for (int i = 0; i < 8; i++) step(1'b0, 32'd0, 1'b1);
        step(1'b1, 32'hFFFF_FFFF, 1'b0); idle(1);
        for (int i = 0; i < 8; i++) step(1'b0, 32'd0, 1'b1);
        idle(3);

        // R5: load then first request
        tag = "R5";
        step(1'b1, 32'hDEAD_BEEF, 1'b0);
        idle(2);
        step(1'b0, 32'd0, 1'b1);
        idle(3);

        // R6: request with load, request during warm-up
        tag = "R6";
        step(1'b1, 32'h0BAD_F00D, 1'b1);
        step(1'b0, 32'd0, 1'b1);
        step(1'b0, 32'd0, 1'b1);
        step(1'b1, 32'h5555_AAAA, 1'b1);
        step(1'b1, 32'h3333_CCCC, 1'b1);
        step(1'b0, 32'd0, 1'b1);
        step(1'b0, 32'd0, 1'b1);
        idle(3);

        // R9: load while a word is in flight
        tag = "R9";
        for (int k = 0; k < 6; k++) begin
            step(1'b0, 32'd0, 1'b1);
            step(1'b1, 32'h1357_9BDF + 32'(k), 1'b0);
            step(1'b0, 32'd0, 1'b1);
            step(1'b0, 32'd0, 1'b1);
        end
        idle(4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule